// File: doc/BRIEF.md
# DDR SDRAM Command and Bank-State Tracker

This block sits on the controller side of a mobile DDR SDRAM link and watches the command pins that the controller drives toward the memory. On every rising clock edge it samples clock enable, chip select, the three command strobes, the bank-address bits and the address bus. It keeps an image of the memory's state: which of the four banks hold an open row and which row that is, which power mode the device is in, and what was last written to the base and the extended mode register.

Any command that the device would reject in its current state produces a one-cycle error pulse and leaves the tracked state untouched. Such commands are a read or write to an idle bank, an activate to an open bank, and a mode-register write or refresh while a row is open. All inputs are plain control pins that are sampled every cycle. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure. Every output is registered and reflects the commands sampled up to and including the previous edge.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When `cs_n` is sampled high with `cke` high in normal mode, the command pins are ignored: bank state, rows and both mode registers keep their values and `err` stays low.
- R2: With `cs_n` low, {cs_n,ras_n,cas_n,we_n} decodes as 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh, 0000 mode-register write. The unlisted code 0110 acts as a no-op.
- R3: An activate to an idle bank selected by `ba` opens it, and `addr` is stored as that bank's row in `open_row[ba*ADDR_W +: ADDR_W]`. The row field keeps its value after the bank closes.
- R4: A read or write to an open bank leaves it open when `addr[10]` is 0. When `addr[10]` is 1 (auto-precharge), the bank is returned to idle.
- R5: A precharge with `addr[10]` = 0 closes only bank `ba`. With `addr[10]` = 1 it closes every bank. A precharge to an idle bank is not an error.
- R6: A mode-register write with all banks idle loads `addr` into `mode_base` when `ba[1]` is 0 and into `mode_ext` when `ba[1]` is 1.
- R7: When `cke` is sampled low in normal mode (`pwr_mode` 0), the command that cycle is not executed. `pwr_mode` becomes 2 (active power-down) if any bank is open. With all banks idle it becomes 3 (self refresh) if the command is auto refresh, and 1 (precharge power-down) otherwise.
- R8: While `pwr_mode` is nonzero, all command inputs are ignored. A cycle with `cke` high returns `pwr_mode` to 0, and the command sampled in that cycle is also ignored.
- R9: `err` is high for exactly the cycle after one of these commands is sampled in normal mode: a read or write to an idle bank, an activate to an open bank, or an auto refresh or mode-register write while any bank is open. The tracked state is then unchanged.
- R10: An active-low synchronous reset clears all banks to idle, sets `pwr_mode` to 0 and both mode registers to 0, and holds `err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as driven to the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Row, column/auto-precharge or op-code field |
| bank_open | output | 2**BA_W | One bit per bank, 1 = row open |
| open_row | output | 2**BA_W*ADDR_W | Row per bank, bank i in bits [i*ADDR_W +: ADDR_W] |
| pwr_mode | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| mode_base | output | ADDR_W | Last op-code written to the base mode register |
| mode_ext | output | ADDR_W | Last op-code written to the extended mode register |
| err | output | 1 | One-cycle pulse on an illegal command |

## Verification
The bench builds the block with its default values: two bank-address bits, giving four banks, a 13-bit address and auto-precharge on bit 10. With four banks, a single-bank precharge can be seen leaving the other banks open while an all-bank precharge clears a mixed set. A 13-bit address lets the bench store row values that differ from bank to bank and place op-codes that set the auto-precharge bit itself. Directed sequences cover each error case, each power-mode entry and exit, and the deselected and unlisted codes. A long run of mixed commands is then compared with the behavioural model on every clock.

// File: rtl/ddr_trk_pkg.sv
`timescale 1ns/1ps
package ddr_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_DESEL
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN      = 2'd0,
    PWR_PRE_PD   = 2'd1,
    PWR_ACT_PD   = 2'd2,
    PWR_SELF_REF = 2'd3
  } pwr_e;

  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = CMD_DESEL;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
`timescale 1ns/1ps
module ddr_cmd_decode
  import ddr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/ddr_power_ctl.sv
`timescale 1ns/1ps
module ddr_power_ctl
  import ddr_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic any_open,
  input  logic is_ref,
  output pwr_e pwr,
  output logic exec_ok
);
  pwr_e pwr_nx;

  always_comb begin
    pwr_nx = pwr;
    if (pwr == PWR_RUN) begin
      if (!cke) begin
        if (any_open)    pwr_nx = PWR_ACT_PD;
        else if (is_ref) pwr_nx = PWR_SELF_REF;
        else             pwr_nx = PWR_PRE_PD;
      end
    end else if (cke) begin
      pwr_nx = PWR_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwr <= PWR_RUN;
    else        pwr <= pwr_nx;
  end

  assign exec_ok = (pwr == PWR_RUN) && cke;
endmodule

// File: rtl/ddr_bank_slot.sv
`timescale 1ns/1ps
module ddr_bank_slot #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row     <= '0;
    end else if (open_en) begin
      is_open <= 1'b1;
      row     <= row_in;
    end else if (close_en) begin
      is_open <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_mode_regs.sv
`timescale 1ns/1ps
module ddr_mode_regs #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         sel_ext,
  input  logic [W-1:0] opcode,
  output logic [W-1:0] base_q,
  output logic [W-1:0] ext_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ext_q  <= '0;
    end else if (wr_en) begin
      if (sel_ext) ext_q  <= opcode;
      else         base_q <= opcode;
    end
  end
endmodule

// File: rtl/ddr_cmd_tracker.sv
`timescale 1ns/1ps
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cke,
  input  logic                           cs_n,
  input  logic                           ras_n,
  input  logic                           cas_n,
  input  logic                           we_n,
  input  logic [BA_W-1:0]                ba,
  input  logic [ADDR_W-1:0]              addr,
  output logic [(1<<BA_W)-1:0]           bank_open,
  output logic [(1<<BA_W)*ADDR_W-1:0]    open_row,
  output logic [1:0]                     pwr_mode,
  output logic [ADDR_W-1:0]              mode_base,
  output logic [ADDR_W-1:0]              mode_ext,
  output logic                           err
);
  localparam int NUM_BANKS = 1 << BA_W;

  cmd_e cmd;
  pwr_e pwr;
  logic exec_ok;
  logic any_open, hit_open, is_access, illegal;
  logic mrs_wr;

  ddr_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign any_open  = |bank_open;
  assign hit_open  = bank_open[ba];
  assign is_access = (cmd == CMD_RD) || (cmd == CMD_WR);

  ddr_power_ctl u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .any_open(any_open),
    .is_ref  (cmd == CMD_REF),
    .pwr     (pwr),
    .exec_ok (exec_ok)
  );
  assign pwr_mode = pwr;

  // Illegal command in the current bank state
  always_comb begin
    illegal = 1'b0;
    if (exec_ok) begin
      unique case (cmd)
        CMD_ACT:          illegal = hit_open;
        CMD_RD, CMD_WR:   illegal = !hit_open;
        CMD_REF, CMD_MRS: illegal = any_open;
        default:          illegal = 1'b0;
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
      logic sel, open_en, close_en;
      assign sel      = (ba == BA_W'(gi));
      assign open_en  = exec_ok && !illegal && (cmd == CMD_ACT) && sel;
      assign close_en = exec_ok && !illegal &&
                        (((cmd == CMD_PRE) && (addr[AP_BIT] || sel)) ||
                         (is_access && sel && addr[AP_BIT]));
      ddr_bank_slot #(.ROW_W(ADDR_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_en (open_en),
        .close_en(close_en),
        .row_in  (addr),
        .is_open (bank_open[gi]),
        .row     (open_row[gi*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

  assign mrs_wr = exec_ok && !illegal && (cmd == CMD_MRS);

  ddr_mode_regs #(.W(ADDR_W)) u_mrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mrs_wr),
    .sel_ext(ba[BA_W-1]),
    .opcode (addr),
    .base_q (mode_base),
    .ext_q  (mode_ext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= illegal;
  end
endmodule

// File: rtl/ddr_trk_checker.sv
`timescale 1ns/1ps
module ddr_trk_checker #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cke,
  input logic                        cs_n,
  input logic                        ras_n,
  input logic                        cas_n,
  input logic                        we_n,
  input logic [BA_W-1:0]             ba,
  input logic [ADDR_W-1:0]           addr,
  input logic [(1<<BA_W)-1:0]        bank_open,
  input logic [(1<<BA_W)*ADDR_W-1:0] open_row,
  input logic [1:0]                  pwr_mode,
  input logic [ADDR_W-1:0]           mode_base,
  input logic [ADDR_W-1:0]           mode_ext,
  input logic                        err
);
  logic run, pins_act, pins_rd, pins_pre;
  assign run      = (pwr_mode == 2'd0) && cke;
  assign pins_act = {cs_n, ras_n, cas_n, we_n} == 4'b0011;
  assign pins_rd  = {cs_n, ras_n, cas_n, we_n} == 4'b0101;
  assign pins_pre = {cs_n, ras_n, cas_n, we_n} == 4'b0010;

  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cs_n) |=> ($stable(bank_open) && $stable(mode_base) && $stable(mode_ext) && !err));

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pins_act && !bank_open[ba]) |=>
      (bank_open[$past(ba)] && open_row[$past(ba)*ADDR_W +: ADDR_W] == $past(addr)));

  assert_pre_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pins_pre && addr[AP_BIT]) |=> (bank_open == '0));

  assert_act_pd_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_mode == 2'd0) && !cke && (|bank_open)) |=> (pwr_mode == 2'd2));

  assert_pd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_mode != 2'd0) && !cke) |=> ($stable(pwr_mode) && $stable(bank_open) &&
                                      $stable(mode_base) && $stable(mode_ext) && !err));

  assert_pd_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_mode != 2'd0) && cke) |=> ((pwr_mode == 2'd0) && $stable(bank_open)));

  assert_rd_idle_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pins_rd && !bank_open[ba]) |=> err);

  assert_err_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(bank_open) && $stable(mode_base) && $stable(mode_ext) && (pwr_mode == 2'd0)));
endmodule

bind ddr_cmd_tracker ddr_trk_checker #(.BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open), .open_row(open_row),
  .pwr_mode(pwr_mode), .mode_base(mode_base), .mode_ext(mode_ext), .err(err)
);

// File: tb/tb_ddr_cmd_tracker.sv
`timescale 1ns/1ps
module tb_ddr_cmd_tracker;
  localparam bit [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                       P_WR = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001,
                       P_MRS = 4'b0000, P_BST = 4'b0110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [3:0] bank_open;
  logic [51:0] open_row;
  logic [1:0] pwr_mode;
  logic [12:0] mode_base, mode_ext;
  logic err;

  always #2.5 clk = ~clk;

  ddr_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open), .open_row(open_row),
    .pwr_mode(pwr_mode), .mode_base(mode_base), .mode_ext(mode_ext), .err(err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string last_tag = "R10 reset";

  // reference state
  bit        m_open [4];
  bit [12:0] m_row  [4];
  int        m_pwr;
  bit [12:0] m_base, m_ext;
  bit        m_err;

  function automatic bit m_any();
    return m_open[0] | m_open[1] | m_open[2] | m_open[3];
  endfunction

  task automatic model_apply(input bit c, input bit [3:0] p, input bit [1:0] b,
                             input bit [12:0] a);
    m_err = 0;
    if (m_pwr != 0) begin
      if (c) m_pwr = 0;
      return;
    end
    if (!c) begin
      if (m_any())        m_pwr = 2;
      else if (p == P_REF) m_pwr = 3;
      else                 m_pwr = 1;
      return;
    end
    case (p)
      P_ACT: if (m_open[b]) m_err = 1; else begin m_open[b] = 1; m_row[b] = a; end
      P_RD, P_WR: if (!m_open[b]) m_err = 1; else if (a[10]) m_open[b] = 0;
      P_PRE: if (a[10]) foreach (m_open[k]) m_open[k] = 0; else m_open[b] = 0;
      P_REF: if (m_any()) m_err = 1;
      P_MRS: if (m_any()) m_err = 1; else if (b[1]) m_ext = a; else m_base = a;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [3:0] eo;
    for (int i = 0; i < 4; i++) eo[i] = m_open[i];
    check(last_tag, "bank_open", 64'(bank_open), 64'(eo));
    for (int i = 0; i < 4; i++)
      check(last_tag, "open_row", 64'(open_row[i*13 +: 13]), 64'(m_row[i]));
    check(last_tag, "pwr_mode", 64'(pwr_mode), 64'(m_pwr));
    check(last_tag, "mode_base", 64'(mode_base), 64'(m_base));
    check(last_tag, "mode_ext", 64'(mode_ext), 64'(m_ext));
    check(last_tag, "err", 64'(err), 64'(m_err));
  endtask

  // compare the result of the previous command, then issue the next one
  task automatic step(input string tag, input bit c, input bit [3:0] p,
                      input bit [1:0] b, input bit [12:0] a);
    @(negedge clk);
    compare_all();
    cke = c; {cs_n, ras_n, cas_n, we_n} = p; ba = b; addr = a;
    model_apply(c, p, b, a);
    last_tag = tag;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
    m_pwr = 0; m_base = 0; m_ext = 0; m_err = 0;
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state is compared by the first step (tag R10)
    step("R2 nop", 1, P_NOP, 0, 0);
    step("R9 read idle bank", 1, P_RD, 1, 13'h0004);
    step("R3 act bank0", 1, P_ACT, 0, 13'h0123);
    step("R9 act open bank", 1, P_ACT, 0, 13'h0456);
    step("R4 write no ap", 1, P_WR, 0, 13'h0010);
    step("R3 act bank2", 1, P_ACT, 2, 13'h1ABC);
    step("R4 read auto-precharge", 1, P_RD, 2, 13'h0408);
    step("R9 mrs while open", 1, P_MRS, 0, 13'h0033);
    step("R9 refresh while open", 1, P_REF, 0, 0);
    step("R1 deselected act", 1, 4'b1011, 1, 13'h0777);
    step("R2 unlisted code", 1, P_BST, 0, 13'h0400);
    step("R7 active power-down", 0, P_NOP, 0, 0);
    step("R8 act ignored in pd", 0, P_ACT, 3, 13'h0F0F);
    step("R8 exit pd ignores act", 1, P_ACT, 3, 13'h0F0F);
    step("R3 act bank3", 1, P_ACT, 3, 13'h0AAA);
    step("R5 pre single bank3", 1, P_PRE, 3, 0);
    step("R3 act bank1", 1, P_ACT, 1, 13'h1555);
    step("R5 pre all", 1, P_PRE, 2, 13'h0400);
    step("R5 pre idle bank", 1, P_PRE, 0, 0);
    step("R6 mrs base", 1, P_MRS, 0, 13'h0432);
    step("R6 mrs ext", 1, P_MRS, 2, 13'h1F01);
    step("R2 refresh idle", 1, P_REF, 0, 0);
    step("R7 precharge power-down", 0, P_NOP, 0, 0);
    step("R8 mrs ignored in pd", 0, P_MRS, 0, 13'h1111);
    step("R8 exit", 1, P_NOP, 0, 0);
    step("R7 self refresh", 0, P_REF, 0, 0);
    step("R8 hold self refresh", 0, P_ACT, 0, 13'h0001);
    step("R8 exit self refresh", 1, P_NOP, 0, 0);
    step("R1 deselected in run", 1, 4'b1000, 2, 13'h0999);
    for (int n = 0; n < 600; n++) begin
      bit [3:0] p;
      int sel = $urandom_range(0, 9);
      case (sel)
        0: p = P_NOP; 1, 2: p = P_ACT; 3: p = P_RD; 4: p = P_WR;
        5, 6: p = P_PRE; 7: p = P_REF; 8: p = P_MRS;
        default: p = 4'(8 + $urandom_range(0, 7));
      endcase
      step("R9 mixed traffic", ($urandom_range(0, 9) != 0), p,
           2'($urandom_range(0, 3)), 13'($urandom));
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule